// File: doc/BRIEF.md
# Error and Mode Status Register

This block holds the run-state and fault flags of a serial controller. Eight flags live in it. Two describe how the controller runs: the enable flag selects configuration mode (cleared) or active mode (set), and the master-select flag picks the controller's role. Six sticky flags record faults: mode error, transmit overflow, receive overflow, abort, transmit underflow and receive underflow. A live busy indication from the data path is shown beside them in the same status word.

Software never writes the flags directly. It issues a 16-bit command word in which every flag owns one set bit and one clear bit. A single write can therefore raise some flags, drop others and leave the rest alone, with no read-modify-write. Hardware fault events from the data path set the error flags. Each event counts only while the controller is in active mode and its kind is enabled by the matching control bit. The mode error kind has no enable bit. A single error output is raised while any error flag is held.

Top module: `errmode_stat_reg`

## Requirements
- R1: After reset, every error flag and the enable flag are 0, the master-select flag takes the value of parameter `RST_MASTER`, and `err_out` is 0.
- R2: A valid command sets flags through these bits, and many flags may be set in one write: bit 1 enable, bit 3 master select, bit 7 mode error, bit 12 transmit overflow, bit 13 receive overflow, bit 14 abort, bit 15 transmit underflow, bit 5 receive underflow.
- R3: A valid command clears flags through these bits: bit 0 enable, bit 2 master select, bit 6 mode error, bit 8 transmit overflow, bit 9 receive overflow, bit 10 abort, bit 11 transmit underflow, bit 4 receive underflow.
- R4: When the set bit and the clear bit of one flag are both 1 in a valid command, that flag keeps its value.
- R5: In active mode, a hardware event whose kind is enabled sets its flag on the next clock edge. The `hw_err` index is 0 mode error, 1 transmit overflow, 2 receive overflow, 3 abort, 4 transmit underflow and 5 receive underflow. The mode error kind is always enabled.
- R6: A hardware event whose kind is disabled in `err_kind_en` does not set its flag. The `err_kind_en` index is 0 transmit overflow, 1 receive overflow, 2 abort, 3 transmit underflow and 4 receive underflow.
- R7: In configuration mode (enable flag 0), hardware events of every kind are ignored.
- R8: When an accepted hardware event and a software clear hit the same flag in the same cycle, the flag ends up set.
- R9: `err_out` is 1 exactly while at least one error flag is set. It stays 1 until software clears all of them. The enable and master-select flags do not drive it.
- R10: The `status` word has these bit positions: 0 enable, 1 master select, 7 mode error, 8 transmit overflow, 9 receive overflow, 10 abort, 11 transmit underflow, 12 receive underflow, 13 busy. Bit 13 follows `busy_in` in the same cycle. All other bits are 0.
- R11: `cmd_word` has no effect while `cmd_valid` is 0.
- R12: `active_mode` and `master_sel` show the enable and master-select flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 16 | Paired set/clear command bits |
| err_kind_en | input | 5 | Per-kind hardware error enables |
| hw_err | input | 6 | Hardware fault event pulses |
| busy_in | input | 1 | Live busy indication from the data path |
| status | output | 16 | Assembled flag word |
| active_mode | output | 1 | Enable flag (1 = active mode) |
| master_sel | output | 1 | Master-select flag |
| err_out | output | 1 | OR of all error flags |

## Verification
The bench builds the block with `RST_MASTER` set to 1 instead of its default of 0. This makes the reset check see a non-zero master flag, and it shows that the enable and master-select flags stay out of `err_out`. `RST_STAGES` stays at 2, and the bench waits out the synchronizer before the first command. Under these values the bench reaches every command bit, both event-gating paths, the race between a hardware event and a software clear, and the return to configuration mode.

// File: rtl/errmode_stat_pkg.sv
package errmode_stat_pkg;

  localparam int CMD_W       = 16;
  localparam int STAT_W      = 16;
  localparam int NUM_FLAGS   = 8;
  localparam int NUM_HW_ERR  = 6;
  localparam int NUM_KIND_EN = NUM_HW_ERR - 1;
  localparam int BUSY_POS    = 13;

  // flag index: 0 enable, 1 master, 2 mode err, 3 tx ovf, 4 rx ovf,
  // 5 abort, 6 tx udf, 7 rx udf
  localparam int FL_EN    = 0;
  localparam int FL_MS    = 1;
  localparam int FL_ERR0  = 2;

  function automatic int stat_pos(input int idx);
    return (idx < FL_ERR0) ? idx : idx + 5;
  endfunction

  function automatic int set_pos(input int idx);
    case (idx)
      0:       return 1;
      1:       return 3;
      2:       return 7;
      3:       return 12;
      4:       return 13;
      5:       return 14;
      6:       return 15;
      default: return 5;
    endcase
  endfunction

  function automatic int clr_pos(input int idx);
    case (idx)
      0:       return 0;
      1:       return 2;
      2:       return 6;
      3:       return 8;
      4:       return 9;
      5:       return 10;
      6:       return 11;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/errmode_rst_sync.sv
module errmode_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/errmode_cmd_dec.sv
module errmode_cmd_dec
  import errmode_stat_pkg::*;
(
  input  logic                 cmd_valid,
  input  logic [CMD_W-1:0]     cmd_word,
  output logic [NUM_FLAGS-1:0] sw_set,
  output logic [NUM_FLAGS-1:0] sw_clr
);
  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_map
    localparam int SP = set_pos(i);
    localparam int CP = clr_pos(i);
    assign sw_set[i] = cmd_valid & cmd_word[SP];
    assign sw_clr[i] = cmd_valid & cmd_word[CP];
  end
endmodule

// File: rtl/errmode_flag_cell.sv
module errmode_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_set,
  input  logic sw_clr,
  output logic flag_q
);
  logic flag_d;
  logic flag_ce;

  always_comb begin
    flag_ce = hw_set | (sw_set ^ sw_clr);
    if (hw_set)      flag_d = 1'b1;
    else if (sw_set) flag_d = 1'b1;
    else             flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= RST_VAL;
    else if (flag_ce) flag_q <= flag_d;
  end
endmodule

// File: rtl/errmode_stat_reg.sv
module errmode_stat_reg
  import errmode_stat_pkg::*;
#(
  parameter logic RST_MASTER = 1'b0,
  parameter int   RST_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [CMD_W-1:0]       cmd_word,
  input  logic [NUM_KIND_EN-1:0] err_kind_en,
  input  logic [NUM_HW_ERR-1:0]  hw_err,
  input  logic                   busy_in,
  output logic [STAT_W-1:0]      status,
  output logic                   active_mode,
  output logic                   master_sel,
  output logic                   err_out
);
  localparam int NUM_ERR = NUM_FLAGS - FL_ERR0;

  logic                 rst_core_n;
  logic [NUM_FLAGS-1:0] sw_set;
  logic [NUM_FLAGS-1:0] sw_clr;
  logic [NUM_FLAGS-1:0] hw_set;
  logic [NUM_FLAGS-1:0] flags_q;
  logic [NUM_HW_ERR-1:0] kind_ok;

  errmode_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  errmode_cmd_dec u_dec (
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .sw_set    (sw_set),
    .sw_clr    (sw_clr)
  );

  // mode error has no enable bit; others take one each
  assign kind_ok = {err_kind_en, 1'b1};

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
    if (i < FL_ERR0) begin : g_mode
      assign hw_set[i] = 1'b0;
    end else begin : g_err
      assign hw_set[i] = flags_q[FL_EN] & kind_ok[i-FL_ERR0] & hw_err[i-FL_ERR0];
    end
    errmode_flag_cell #(
      .RST_VAL ((i == FL_MS) ? RST_MASTER : 1'b0)
    ) u_cell (
      .clk    (clk),
      .rst_n  (rst_core_n),
      .hw_set (hw_set[i]),
      .sw_set (sw_set[i]),
      .sw_clr (sw_clr[i]),
      .flag_q (flags_q[i])
    );
  end

  always_comb begin
    status = '0;
    for (int i = 0; i < NUM_FLAGS; i++) status[stat_pos(i)] = flags_q[i];
    status[BUSY_POS] = busy_in;
  end

  assign active_mode = flags_q[FL_EN];
  assign master_sel  = flags_q[FL_MS];
  assign err_out     = |flags_q[FL_ERR0 +: NUM_ERR];
endmodule

// File: rtl/errmode_stat_chk.sv
module errmode_stat_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic [15:0] cmd_word,
  input logic [4:0]  err_kind_en,
  input logic [5:0]  hw_err,
  input logic [15:0] status,
  input logic        err_out
);
  // R3: clear without set or event drops transmit overflow
  p_sw_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_word[8] && !cmd_word[12] && !hw_err[1] |=> !status[8]);

  // R8: accepted event beats a same-cycle clear
  p_hw_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    status[0] && err_kind_en[0] && hw_err[1] |=> status[8]);

  // R4: set and clear together hold mode error
  p_pair_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_word[7] && cmd_word[6] && !(status[0] && hw_err[0])
    |=> $stable(status[7]));

  // R7: configuration mode ignores events
  p_cfg_ignore_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !status[0] && !cmd_valid |=> $stable(status[12:7]));

  // R11: nothing changes without a command or event
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid && hw_err == 6'd0 |=> $stable(status[12:0]));

  // R6: disabled receive overflow never sets by hardware
  p_kind_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !err_kind_en[1] && hw_err[2] && !(cmd_valid && cmd_word[13]) && !status[9]
    |=> !status[9]);

  // R9: error output rises only after a command or event
  p_err_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_out) |-> $past(cmd_valid || hw_err != 6'd0));

  // R9: error output sticks until software acts
  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err_out && !cmd_valid |=> err_out);
endmodule

bind errmode_stat_reg errmode_stat_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_core_n),
  .cmd_valid   (cmd_valid),
  .cmd_word    (cmd_word),
  .err_kind_en (err_kind_en),
  .hw_err      (hw_err),
  .status      (status),
  .err_out     (err_out)
);

// File: tb/sim_errmode_stat_reg.sv
`timescale 1ns/1ps
module sim_errmode_stat_reg;
  logic        clk;
  logic        rst_n;
  logic        cmd_valid;
  logic [15:0] cmd_word;
  logic [4:0]  err_kind_en;
  logic [5:0]  hw_err;
  logic        busy_in;
  logic [15:0] status;
  logic        active_mode;
  logic        master_sel;
  logic        err_out;

  int checks;
  int failures;
  bit done;

  errmode_stat_reg #(.RST_MASTER(1'b1), .RST_STAGES(2)) u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .err_kind_en(err_kind_en), .hw_err(hw_err), .busy_in(busy_in),
    .status(status), .active_mode(active_mode), .master_sel(master_sel),
    .err_out(err_out)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // apply one cycle of stimulus, sample after the edge
  task automatic step(input logic v, input logic [15:0] w, input logic [5:0] ev);
    @(negedge clk);
    cmd_valid = v; cmd_word = w; hw_err = ev;
    @(posedge clk); #1;
    cmd_valid = 1'b0; cmd_word = 16'h0; hw_err = 6'h0;
  endtask

  task automatic t_reset;
    chk("R1 status", status, 16'h0002);
    chk("R1 err_out", {15'h0, err_out}, 16'h0);
    chk("R12 master_sel", {15'h0, master_sel}, 16'h1);
    chk("R12 active_mode", {15'h0, active_mode}, 16'h0);
  endtask

  task automatic t_busy;
    @(negedge clk); busy_in = 1'b1; #1;
    chk("R10 busy high", status, 16'h2002);
    busy_in = 1'b0; #1;
    chk("R10 busy low", status, 16'h0002);
  endtask

  task automatic t_cfg_ignore;
    err_kind_en = 5'h1F;
    step(1'b0, 16'h0, 6'h3F);
    chk("R7 config mode ignores events", status, 16'h0002);
  endtask

  task automatic t_set_many;
    step(1'b1, 16'hF0A2, 6'h0);
    chk("R2 set all", status, 16'h1F83);
    chk("R9 err_out set", {15'h0, err_out}, 16'h1);
  endtask

  task automatic t_clear_some;
    step(1'b1, 16'h0110, 6'h0);
    chk("R3 clear tx ovf and rx udf", status, 16'h0E83);
  endtask

  task automatic t_pair;
    step(1'b1, 16'h00C3, 6'h0);
    chk("R4 set+clear hold", status, 16'h0E83);
  endtask

  task automatic t_no_valid;
    step(1'b0, 16'hFFFF, 6'h0);
    chk("R11 invalid command ignored", status, 16'h0E83);
  endtask

  task automatic t_clear_errs;
    step(1'b1, 16'h0F50, 6'h0);
    chk("R3 clear all errors", status, 16'h0003);
    chk("R9 err_out low with flags only", {15'h0, err_out}, 16'h0);
  endtask

  task automatic t_hw_events;
    err_kind_en = 5'b00101;
    step(1'b0, 16'h0, 6'b001111);
    chk("R5 R6 gated events", status, 16'h0583);
    step(1'b0, 16'h0, 6'h0);
    chk("R9 err_out sticky", {15'h0, err_out}, 16'h1);
  endtask

  task automatic t_race;
    step(1'b1, 16'h0500, 6'b000010);
    chk("R8 hw set beats clear", status, 16'h0183);
  endtask

  task automatic t_underflow;
    err_kind_en = 5'b11000;
    step(1'b0, 16'h0, 6'b110000);
    chk("R5 underflow events", status, 16'h1983);
  endtask

  task automatic t_modes;
    step(1'b1, 16'h0001, 6'h0);
    chk("R12 enter config", status, 16'h1982);
    chk("R12 active_mode low", {15'h0, active_mode}, 16'h0);
    err_kind_en = 5'h1F;
    step(1'b1, 16'h0F50, 6'h3F);
    chk("R7 events ignored, clears applied", status, 16'h0002);
    step(1'b1, 16'h0004, 6'h0);
    chk("R12 clear master", {15'h0, master_sel}, 16'h0);
    step(1'b1, 16'h000A, 6'h0);
    chk("R2 set master and enable", status, 16'h0003);
  endtask

  initial begin
    checks = 0; failures = 0; done = 1'b0;
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_word = 16'h0;
    err_kind_en = 5'h0; hw_err = 6'h0; busy_in = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_busy();
    t_cfg_ignore();
    t_set_many();
    t_clear_some();
    t_pair();
    t_no_valid();
    t_clear_errs();
    t_hw_events();
    t_race();
    t_underflow();
    t_modes();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #40000;
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule